// File: doc/BRIEF.md
# Integer ALU with Compare-to-Register

This block is the integer execution unit of a 32-bit processor pipeline. A decoder hands it two operand words and a 5-bit operation select, and it returns one 32-bit result word in the same cycle, with no registers on the path. It covers wrap-around add and subtract, the low word of a multiply, five bitwise functions (including the inverted forms nor and xnor), three shift forms, byte and halfword sign extension, and six comparisons.

Comparisons do not set flags. They produce a full result word holding 1 when the relation is true and 0 when it is false, so the outcome can be written straight to a general register. Several assembler idioms reduce to plain operations here: a register move is an or with a zero second operand, a bitwise not is an xnor with a zero second operand, and move-immediate and no-op are adds whose first operand is zero.

Inside, a control module turns the operation select into a small bundle of strobes, and a datapath module computes every function and picks one of them.

Top module: `int_alu`

## Requirements
- R1: Select 0 returns opA+opB and select 1 returns opA-opB. Both wrap modulo 2^32 and have no overflow indication.
- R2: Select 2 returns the low 32 bits of the product opA*opB.
- R3: Selects 3 to 7 return and, or, xor, nor (the inverse of or) and xnor (the inverse of xor). Or with a zero opB returns opA (move), and xnor with a zero opB returns ~opA (not).
- R4: Select 8 shifts opA left and fills with zeros. Select 9 shifts right arithmetically, filling with opA[31]. Select 10 shifts right logically and fills with zeros.
- R5: For the three shifts, only opB[4:0] is used as the shift amount. opB[31:5] has no effect.
- R6: Select 11 copies opA[7] into bits 31:8 above opA[7:0]. Select 12 copies opA[15] into bits 31:16 above opA[15:0].
- R7: Selects 13 to 18 compare opA with opB as equal, not equal, signed greater, signed greater-or-equal, unsigned greater and unsigned greater-or-equal. The result is 32'd1 when the relation holds and 32'd0 when it does not.
- R8: Select values 19 to 31 are undefined and return 32'd0.
- R9: The result is a purely combinational function of opA, opB and opSel, valid in the same cycle with no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 32 | First operand word |
| opB | input | 32 | Second operand word, also the shift amount source |
| opSel | input | 5 | Operation select, encoded as in the requirements |
| result | output | 32 | Result word |

## Verification
The bench goes after the places where signed and unsigned handling diverge. Comparing 0x80000000 with 1 catches a comparator that ignores signedness, because it would give the same answer for signed and unsigned greater. Shifts use opB values with the upper bits set, so a design that reads more than five bits shifts everything out to zero. Arithmetic right shifts of negative values catch a design that fills with zeros instead of the sign bit. Sign extension uses operands whose bit 7 or bit 15 differs from the bits above it, so that taking the wrong sign bit is exposed. Subtraction is driven across zero to check wrap-around, and undefined selects must return zero rather than some leftover result.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int ALU_W = 32;

  typedef enum logic [4:0] {
    OP_ADD    = 5'd0,
    OP_SUB    = 5'd1,
    OP_MUL    = 5'd2,
    OP_AND    = 5'd3,
    OP_OR     = 5'd4,
    OP_XOR    = 5'd5,
    OP_NOR    = 5'd6,
    OP_XNOR   = 5'd7,
    OP_SLL    = 5'd8,
    OP_SRA    = 5'd9,
    OP_SRL    = 5'd10,
    OP_SEXTB  = 5'd11,
    OP_SEXTH  = 5'd12,
    OP_CMPEQ  = 5'd13,
    OP_CMPNE  = 5'd14,
    OP_CMPGT  = 5'd15,
    OP_CMPGE  = 5'd16,
    OP_CMPGTU = 5'd17,
    OP_CMPGEU = 5'd18
  } aluOp_e;

  typedef enum logic [2:0] {
    UNIT_NONE  = 3'd0,
    UNIT_ARITH = 3'd1,
    UNIT_MUL   = 3'd2,
    UNIT_LOGIC = 3'd3,
    UNIT_SHIFT = 3'd4,
    UNIT_EXT   = 3'd5,
    UNIT_CMP   = 3'd6
  } unitSel_e;

  typedef enum logic [1:0] {
    LOP_AND = 2'd0,
    LOP_OR  = 2'd1,
    LOP_XOR = 2'd2
  } logicOp_e;

  typedef struct packed {
    unitSel_e unit;
    logic     subtract;
    logicOp_e logicOp;
    logic     logicInvert;
    logic     shRight;
    logic     shArith;
    logic     extHalf;
    logic     cmpUnsigned;
    logic     acceptEq;
    logic     acceptGt;
    logic     acceptLt;
  } ctrlStrobes_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [4:0]   opSel,
  output ctrlStrobes_t ctrl
);

  always_comb begin
    ctrl = '0;
    case (opSel)
      OP_ADD:    ctrl.unit = UNIT_ARITH;
      OP_SUB:    begin ctrl.unit = UNIT_ARITH; ctrl.subtract = 1'b1; end
      OP_MUL:    ctrl.unit = UNIT_MUL;
      OP_AND:    begin ctrl.unit = UNIT_LOGIC; ctrl.logicOp = LOP_AND; end
      OP_OR:     begin ctrl.unit = UNIT_LOGIC; ctrl.logicOp = LOP_OR; end
      OP_XOR:    begin ctrl.unit = UNIT_LOGIC; ctrl.logicOp = LOP_XOR; end
      OP_NOR:    begin ctrl.unit = UNIT_LOGIC; ctrl.logicOp = LOP_OR;  ctrl.logicInvert = 1'b1; end
      OP_XNOR:   begin ctrl.unit = UNIT_LOGIC; ctrl.logicOp = LOP_XOR; ctrl.logicInvert = 1'b1; end
      OP_SLL:    ctrl.unit = UNIT_SHIFT;
      OP_SRA:    begin ctrl.unit = UNIT_SHIFT; ctrl.shRight = 1'b1; ctrl.shArith = 1'b1; end
      OP_SRL:    begin ctrl.unit = UNIT_SHIFT; ctrl.shRight = 1'b1; end
      OP_SEXTB:  ctrl.unit = UNIT_EXT;
      OP_SEXTH:  begin ctrl.unit = UNIT_EXT; ctrl.extHalf = 1'b1; end
      OP_CMPEQ:  begin ctrl.unit = UNIT_CMP; ctrl.acceptEq = 1'b1; end
      OP_CMPNE:  begin ctrl.unit = UNIT_CMP; ctrl.acceptGt = 1'b1; ctrl.acceptLt = 1'b1; end
      OP_CMPGT:  begin ctrl.unit = UNIT_CMP; ctrl.acceptGt = 1'b1; end
      OP_CMPGE:  begin ctrl.unit = UNIT_CMP; ctrl.acceptGt = 1'b1; ctrl.acceptEq = 1'b1; end
      OP_CMPGTU: begin ctrl.unit = UNIT_CMP; ctrl.cmpUnsigned = 1'b1; ctrl.acceptGt = 1'b1; end
      OP_CMPGEU: begin
        ctrl.unit = UNIT_CMP; ctrl.cmpUnsigned = 1'b1;
        ctrl.acceptGt = 1'b1; ctrl.acceptEq = 1'b1;
      end
      default:   ctrl = '0;
    endcase
  end

  // A compare never accepts all three relations, so its result cannot be stuck at 1
  always_comb begin
    if (ctrl.unit == UNIT_CMP)
      AST_CMP_NOT_CONST: assert ($countones({ctrl.acceptEq, ctrl.acceptGt, ctrl.acceptLt}) inside {1, 2}); // R7
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int DATA_W = ALU_W,
  parameter int BYTE_W = 8,
  parameter int HALF_W = 16
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  ctrlStrobes_t      ctrl,
  output logic [DATA_W-1:0] result
);

  localparam int SHAMT_W = $clog2(DATA_W);

  logic [DATA_W-1:0]  addendB;
  logic [DATA_W-1:0]  arithRes;
  logic [DATA_W-1:0]  mulRes;
  logic [DATA_W-1:0]  logicRaw;
  logic [DATA_W-1:0]  logicRes;
  logic [SHAMT_W-1:0] shamt;
  logic [DATA_W-1:0]  shiftRes;
  logic [DATA_W-1:0]  extRes;
  logic [DATA_W-1:0]  cmpRes;
  logic               isEq;
  logic               isGt;
  logic               isLt;

  // one adder serves add and subtract: invert opB and carry in one
  assign addendB  = ctrl.subtract ? ~opB : opB;
  assign arithRes = opA + addendB + {{(DATA_W-1){1'b0}}, ctrl.subtract};

  assign mulRes = opA * opB;

  always_comb begin
    case (ctrl.logicOp)
      LOP_AND: logicRaw = opA & opB;
      LOP_OR:  logicRaw = opA | opB;
      LOP_XOR: logicRaw = opA ^ opB;
      default: logicRaw = '0;
    endcase
  end
  assign logicRes = ctrl.logicInvert ? ~logicRaw : logicRaw;

  assign shamt = opB[SHAMT_W-1:0];
  always_comb begin
    if (!ctrl.shRight)
      shiftRes = opA << shamt;
    else if (ctrl.shArith)
      shiftRes = DATA_W'($signed(opA) >>> shamt);
    else
      shiftRes = opA >> shamt;
  end

  // both extension widths come from parameters; the generate guards degenerate sizes
  generate
    if (DATA_W > HALF_W && HALF_W > BYTE_W) begin : g_ext
      logic [DATA_W-1:0] byteExt;
      logic [DATA_W-1:0] halfExt;
      assign byteExt = {{(DATA_W-BYTE_W){opA[BYTE_W-1]}}, opA[BYTE_W-1:0]};
      assign halfExt = {{(DATA_W-HALF_W){opA[HALF_W-1]}}, opA[HALF_W-1:0]};
      assign extRes  = ctrl.extHalf ? halfExt : byteExt;
    end else begin : g_noext
      assign extRes = opA;
    end
  endgenerate

  assign isEq   = (opA == opB);
  assign isGt   = ctrl.cmpUnsigned ? (opA > opB) : ($signed(opA) > $signed(opB));
  assign isLt   = !isEq && !isGt;
  assign cmpRes = {{(DATA_W-1){1'b0}},
                   (isEq & ctrl.acceptEq) | (isGt & ctrl.acceptGt) | (isLt & ctrl.acceptLt)};

  always_comb begin
    case (ctrl.unit)
      UNIT_ARITH: result = arithRes;
      UNIT_MUL:   result = mulRes;
      UNIT_LOGIC: result = logicRes;
      UNIT_SHIFT: result = shiftRes;
      UNIT_EXT:   result = extRes;
      UNIT_CMP:   result = cmpRes;
      default:    result = '0;
    endcase
  end

  always_comb begin
    if (ctrl.unit == UNIT_CMP)
      AST_CMP_IS_BOOL: assert (result[DATA_W-1:1] == '0); // R7
    if (ctrl.unit == UNIT_ARITH && ctrl.subtract)
      AST_SUB_INVERTS_ADD: assert (result + opB == opA); // R1
    if (ctrl.unit == UNIT_SHIFT && ctrl.shRight && !ctrl.shArith && shamt != '0)
      AST_SRL_ZERO_TOP: assert (result[DATA_W-1] == 1'b0); // R4
    if (ctrl.unit == UNIT_EXT && !ctrl.extHalf)
      AST_SEXTB_FILL: assert (result[DATA_W-1:BYTE_W] == {(DATA_W-BYTE_W){result[BYTE_W-1]}}); // R6
    if (ctrl.unit == UNIT_NONE)
      AST_UNDEF_ZERO: assert (result == '0); // R8
  end

endmodule

// File: rtl/int_alu.sv
module int_alu
  import alu_pkg::*;
#(
  parameter int DATA_W = ALU_W
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [4:0]        opSel,
  output logic [DATA_W-1:0] result
);

  ctrlStrobes_t ctrl;

  alu_ctrl ctrl_i (
    .opSel (opSel),
    .ctrl  (ctrl)
  );

  alu_datapath #(.DATA_W(DATA_W)) dp_i (
    .opA    (opA),
    .opB    (opB),
    .ctrl   (ctrl),
    .result (result)
  );

endmodule

// File: tb/int_alu_tb_top.sv
module int_alu_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [4:0]  opSel = '0;
  logic [31:0] result;

  int errCount = 0;
  int chkCount = 0;
  int cycles   = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_alu dut_i (
    .opA    (opA),
    .opB    (opB),
    .opSel  (opSel),
    .result (result)
  );

  function automatic string reqOf(input logic [4:0] op);
    if (op <= 1) return "R1";
    if (op == 2) return "R2";
    if (op <= 7) return "R3";
    if (op <= 10) return "R4";
    if (op <= 12) return "R6";
    if (op <= 18) return "R7";
    return "R8";
  endfunction

  function automatic logic [31:0] refModel(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b);
    logic [63:0] prod;
    logic [31:0] fillMask;
    int unsigned s;
    s = b % 32;
    fillMask = ~(32'hFFFF_FFFF >> s);
    prod = {32'd0, a} * {32'd0, b};
    case (op)
      5'd0:  return a + b;
      5'd1:  return a + (~b + 32'd1);
      5'd2:  return prod[31:0];
      5'd3:  return a & b;
      5'd4:  return a | b;
      5'd5:  return a ^ b;
      5'd6:  return ~a & ~b;
      5'd7:  return (a & b) | (~a & ~b);
      5'd8:  return a << s;
      5'd9:  return (a >> s) | (a[31] ? fillMask : 32'd0);
      5'd10: return a >> s;
      5'd11: return a[7]  ? {24'hFFFFFF, a[7:0]}  : {24'h0, a[7:0]};
      5'd12: return a[15] ? {16'hFFFF, a[15:0]}   : {16'h0, a[15:0]};
      5'd13: return (a == b) ? 32'd1 : 32'd0;
      5'd14: return (a != b) ? 32'd1 : 32'd0;
      5'd15: return ($signed(a) > $signed(b)) ? 32'd1 : 32'd0;
      5'd16: return ($signed(a) >= $signed(b)) ? 32'd1 : 32'd0;
      5'd17: return (a > b) ? 32'd1 : 32'd0;
      5'd18: return (a >= b) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    chkCount++;
    if (got !== exp) begin
      errCount++;
      $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h", req, opSel, opA, opB, got, exp);
    end
  endtask

  // drive away from the edge, sample one time unit after the next rising edge
  task automatic apply(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b, input string req);
    @(negedge clk);
    opSel = op; opA = a; opB = b;
    @(posedge clk);
    #1;
    check(req, result, refModel(op, a, b));
  endtask

  task automatic applyExp(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                          input string req, input logic [31:0] exp);
    @(negedge clk);
    opSel = op; opA = a; opB = b;
    @(posedge clk);
    #1;
    check(req, result, exp);
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG && !done) begin
      errCount++;
      chkCount++;
      $display("FAIL watchdog actual=%0d cycles expected<%0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errCount, chkCount);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'hA1B2));
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #1;
    // idle inputs: add of zeros gives zero (R1, R9)
    check("R1", result, 32'd0);

    // R1 wrap-around
    applyExp(5'd0, 32'hFFFF_FFFF, 32'd1, "R1", 32'd0);
    applyExp(5'd1, 32'd0, 32'd1, "R1", 32'hFFFF_FFFF);
    applyExp(5'd1, 32'h8000_0000, 32'd1, "R1", 32'h7FFF_FFFF);
    // R2 low product word
    applyExp(5'd2, 32'h0001_0000, 32'h0001_0003, "R2", 32'h0003_0000);
    applyExp(5'd2, 32'hFFFF_FFFF, 32'd5, "R2", 32'hFFFF_FFFB);
    // R3 move and not idioms, nor/xnor
    applyExp(5'd4, 32'h1234_5678, 32'd0, "R3", 32'h1234_5678);
    applyExp(5'd7, 32'h1234_5678, 32'd0, "R3", 32'hEDCB_A987);
    applyExp(5'd6, 32'hF0F0_0000, 32'h0F00_000F, "R3", 32'h000F_FFF0);
    // R4 fill behaviour
    applyExp(5'd9, 32'h8000_0000, 32'd31, "R4", 32'hFFFF_FFFF);
    applyExp(5'd10, 32'h8000_0000, 32'd31, "R4", 32'd1);
    applyExp(5'd8, 32'h0000_0003, 32'd31, "R4", 32'h8000_0000);
    // R5 upper bits of the amount ignored
    applyExp(5'd8, 32'h0000_0001, 32'hFFFF_FFE4, "R5", 32'h0000_0010);
    applyExp(5'd10, 32'hF000_0000, 32'h0000_0020, "R5", 32'hF000_0000);
    applyExp(5'd9, 32'h8000_0000, 32'h0000_0124, "R5", 32'hF800_0000);
    // R6 sign bit taken from the right position
    applyExp(5'd11, 32'h0000_0080, 32'd0, "R6", 32'hFFFF_FF80);
    applyExp(5'd11, 32'hFFFF_FF7F, 32'd0, "R6", 32'h0000_007F);
    applyExp(5'd12, 32'h0000_8001, 32'd0, "R6", 32'hFFFF_8001);
    applyExp(5'd12, 32'hFFFF_7FFF, 32'd0, "R6", 32'h0000_7FFF);
    // R7 signed versus unsigned
    applyExp(5'd15, 32'h8000_0000, 32'd1, "R7", 32'd0);
    applyExp(5'd17, 32'h8000_0000, 32'd1, "R7", 32'd1);
    applyExp(5'd16, 32'h5, 32'h5, "R7", 32'd1);
    applyExp(5'd18, 32'hFFFF_FFFF, 32'h0, "R7", 32'd1);
    applyExp(5'd14, 32'h5, 32'h5, "R7", 32'd0);
    applyExp(5'd13, 32'h5, 32'h5, "R7", 32'd1);
    // R8 undefined selects
    for (int op = 19; op < 32; op++)
      applyExp(op[4:0], 32'hDEAD_BEEF, 32'h1234_5678, "R8", 32'd0);

    // random sweep over every defined select
    for (int i = 0; i < 300; i++) begin
      for (int op = 0; op < 19; op++) begin
        logic [31:0] a;
        logic [31:0] b;
        a = $urandom();
        b = $urandom();
        if (($urandom() % 8) == 0) b = a;
        apply(op[4:0], a, b, reqOf(op[4:0]));
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errCount, chkCount);
    $finish;
  end

endmodule